// File: doc/BRIEF.md
# Store Buffer with Load Forwarding and Write Barrier

This block sits between one core's store port and that core's private data cache. A store to a line the core may not yet write is parked in a small queue. In the same cycle a read-invalidate request for that line is raised, and the core moves on. A coherence stub outside the block watches the oldest parked entry. It raises a grant once every invalidation answer for that line has come back. The entry is then written to the cache through a single write port. Entries leave strictly in the order they arrived.

Loads from the same core look into the queue before they take data from the cache. When more than one parked entry holds the load's line, the newest one supplies the data. A store whose line is already writable may skip the queue and go straight to the cache. It may do so only when nothing in the queue could be overtaken: no other entry for that line, no commit in the same cycle, and no open barrier.

A write barrier marks every entry parked so far. No later store is accepted until all of those entries have committed. This holds even when the later store's line is held exclusively. The barrier closes in the cycle the queue drains, so a store offered in the following cycle is accepted.

Top module: `store_buffer`

## Requirements
- R1: A store accepted while its line is not writable, or while bypass is blocked, is parked at the tail of the queue. In that same cycle `rdinv_valid` is 1 and `rdinv_addr` equals the store's address.
- R2: The oldest entry is written to the cache (`cwr_valid`=1, with its address and data) only in a cycle where `head_valid` and `head_granted` are both 1. The entry leaves the queue at that clock edge.
- R3: `ld_hit` is 1 when any parked entry holds `ld_addr`. `ld_data` then carries the data of the newest such entry. Otherwise `ld_hit` is 0 and `ld_data` equals `cache_rd_data`.
- R4: With DEPTH entries parked, `st_ready` is 0 and an offered store is not taken.
- R5: Entries commit in arrival order. `head_valid` and `head_addr` always describe the oldest parked entry.
- R6: An accepted store bypasses the queue when all four of these hold: `st_writable` is 1, no barrier is pending, no commit happens in that cycle, and no parked entry holds its address. It then appears on the cache write port in the same cycle and is not parked.
- R7: When `bar_valid` is 1 in a cycle whose clock edge leaves the queue non-empty, a barrier becomes pending. While a barrier is pending, `st_ready` is 0, even for stores to writable lines.
- R8: A pending barrier clears at the clock edge where the queue becomes empty. `st_ready` is 1 in the next cycle unless the queue is full. A barrier raised while the queue ends the cycle empty has no effect.
- R9: After reset the queue is empty, no barrier is pending, `st_ready` is 1, and `head_valid`, `cwr_valid` and `rdinv_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | 8 | Line address of the store |
| st_data | input | 32 | Store data |
| st_writable | input | 1 | Store's line is already held with write permission |
| st_ready | output | 1 | Store accepted this cycle when `st_valid` is 1 |
| bar_valid | input | 1 | Write barrier issued after this cycle's store |
| rdinv_valid | output | 1 | Read-invalidate request for a newly parked store |
| rdinv_addr | output | 8 | Line address of the read-invalidate |
| head_valid | output | 1 | Queue holds at least one entry |
| head_addr | output | 8 | Address of the oldest entry |
| head_granted | input | 1 | Ownership of the head entry's line is granted |
| cwr_valid | output | 1 | Cache write strobe |
| cwr_addr | output | 8 | Cache write address |
| cwr_data | output | 32 | Cache write data |
| ld_addr | input | 8 | Line address of the current load |
| cache_rd_data | input | 32 | Data the cache returns for `ld_addr` |
| ld_hit | output | 1 | Load satisfied from the queue |
| ld_data | output | 32 | Load result |

## Verification
Several directed patterns come first.
- A lone writable store into an empty queue shows the bypass path apart from parking.
- Four non-writable stores, two of them to the same line, fill the queue. This exposes the full stall. Loads to the shared line then tell youngest-match forwarding from oldest-match forwarding.
- Grants given one at a time separate FIFO commit from any other drain order.
- A writable store to a line already parked must be queued, not bypassed. A writable store to an unrelated line may bypass.
- A barrier raised over a non-empty queue, followed by writable stores, shows that exclusive hits are held back. The cycle the stall ends pins down the release timing.

A long stretch of mixed traffic over four line addresses then compares every output against a queue-based model on each cycle. This catches the rarer overlaps: commit and bypass in the same cycle, and a barrier raised as the queue drains.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int SB_ADDR_W = 8;
    localparam int SB_DATA_W = 32;

    typedef logic [SB_ADDR_W-1:0] sb_addr_t;
    typedef logic [SB_DATA_W-1:0] sb_data_t;

    typedef struct packed {
        sb_addr_t addr;
        sb_data_t data;
    } sb_entry_t;

    // Advance a ring index by one, wrapping at depth (any depth, not only powers of two)
    function automatic int unsigned sb_wrap_inc(int unsigned idx, int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  sb_entry_t               push_ent,
    input  logic                    pop,
    output sb_entry_t [DEPTH-1:0]   slots,
    output logic [PTR_W-1:0]        head,
    output logic [CNT_W-1:0]        count
);

    logic [PTR_W-1:0] tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[tail] <= push_ent;
                tail        <= PTR_W'(sb_wrap_inc(int'(tail), DEPTH));
            end
            if (pop) begin
                head <= PTR_W'(sb_wrap_inc(int'(head), DEPTH));
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/sb_match.sv
module sb_match
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sb_entry_t [DEPTH-1:0]   slots,
    input  logic [PTR_W-1:0]        head,
    input  logic [CNT_W-1:0]        count,
    input  sb_addr_t                query,
    output logic                    hit,
    output sb_data_t                data
);

    // Walk oldest to newest; a later match overrides, so the newest wins
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int unsigned slot;
            slot = (int'(head) + i) % DEPTH;
            if (i < int'(count) && slots[slot].addr == query) begin
                hit  = 1'b1;
                data = slots[slot].data;
            end
        end
    end

endmodule

// File: rtl/sb_barrier.sv
module sb_barrier (
    input  logic clk,
    input  logic rst,
    input  logic bar_valid,
    input  logic empty_after,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend | bar_valid) & ~empty_after;
        end
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    input  logic [SB_ADDR_W-1:0] st_addr,
    input  logic [SB_DATA_W-1:0] st_data,
    input  logic                 st_writable,
    output logic                 st_ready,
    input  logic                 bar_valid,
    output logic                 rdinv_valid,
    output logic [SB_ADDR_W-1:0] rdinv_addr,
    output logic                 head_valid,
    output logic [SB_ADDR_W-1:0] head_addr,
    input  logic                 head_granted,
    output logic                 cwr_valid,
    output logic [SB_ADDR_W-1:0] cwr_addr,
    output logic [SB_DATA_W-1:0] cwr_data,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic [SB_DATA_W-1:0] cache_rd_data,
    output logic                 ld_hit,
    output logic [SB_DATA_W-1:0] ld_data
);

    sb_entry_t [DEPTH-1:0] slots;
    logic [PTR_W-1:0]      head;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      cnt_after;
    logic                  pop, push, bypass, accept, bar_pend;
    logic                  st_hit;
    sb_data_t              st_hit_data;
    sb_data_t              fwd_data;
    sb_entry_t             in_ent;

    assign in_ent.addr = st_addr;
    assign in_ent.data = st_data;

    sb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (in_ent),
        .pop      (pop),
        .slots    (slots),
        .head     (head),
        .count    (cnt)
    );

    // Forwarding lookup for the load
    sb_match #(.DEPTH(DEPTH)) u_ld_match (
        .slots (slots),
        .head  (head),
        .count (cnt),
        .query (ld_addr),
        .hit   (ld_hit),
        .data  (fwd_data)
    );

    // Same-line lookup for the incoming store, which blocks bypass
    sb_match #(.DEPTH(DEPTH)) u_st_match (
        .slots (slots),
        .head  (head),
        .count (cnt),
        .query (st_addr),
        .hit   (st_hit),
        .data  (st_hit_data)
    );

    sb_barrier u_bar (
        .clk         (clk),
        .rst         (rst),
        .bar_valid   (bar_valid),
        .empty_after (cnt_after == '0),
        .pend        (bar_pend)
    );

    assign head_valid = (cnt != '0);
    assign head_addr  = slots[head].addr;
    assign pop        = head_valid & head_granted;

    assign st_ready   = (cnt != CNT_W'(DEPTH)) & ~bar_pend;
    assign accept     = st_valid & st_ready;
    assign bypass     = accept & st_writable & ~pop & ~st_hit;
    assign push       = accept & ~bypass;
    assign cnt_after  = cnt + CNT_W'(push) - CNT_W'(pop);

    assign rdinv_valid = push;
    assign rdinv_addr  = st_addr;

    always_comb begin
        cwr_valid = pop | bypass;
        if (pop) begin
            cwr_addr = slots[head].addr;
            cwr_data = slots[head].data;
        end else begin
            cwr_addr = st_addr;
            cwr_data = st_data;
        end
    end

    assign ld_data = ld_hit ? fwd_data : cache_rd_data;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             st_valid,
    input logic             st_ready,
    input logic             head_granted,
    input logic             rdinv_valid,
    input logic             cwr_valid,
    input logic [CNT_W-1:0] cnt,
    input logic             pop,
    input logic             push,
    input logic             bypass,
    input logic             bar_pend
);

    p_rdinv_accepted_r1: assert property (@(posedge clk) disable iff (rst)
        rdinv_valid |-> (st_valid && st_ready));

    p_park_grows_r1: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (cnt == $past(cnt) + 1'b1));

    p_pop_granted_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> (head_granted && cwr_valid));

    p_full_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(DEPTH)) |-> !st_ready);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    p_bypass_alone_r6: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (!pop && !push && cwr_valid));

    p_barrier_stall_r7: assert property (@(posedge clk) disable iff (rst)
        bar_pend |-> !st_ready);

    p_pend_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        bar_pend |-> (cnt != '0));

    p_release_empty_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(bar_pend) |-> (cnt == '0));

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH)) u_sb_chk (
    .clk          (clk),
    .rst          (rst),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .head_granted (head_granted),
    .rdinv_valid  (rdinv_valid),
    .cwr_valid    (cwr_valid),
    .cnt          (cnt),
    .pop          (pop),
    .push         (push),
    .bypass       (bypass),
    .bar_pend     (bar_pend)
);

// File: tb/tb_store_buffer.sv
`timescale 1ns/1ps
module tb_store_buffer;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, st_writable, bar_valid, head_granted;
    logic [7:0]  st_addr, ld_addr;
    logic [31:0] st_data, cache_rd_data;
    logic        st_ready, rdinv_valid, head_valid, cwr_valid, ld_hit;
    logic [7:0]  rdinv_addr, head_addr, cwr_addr;
    logic [31:0] cwr_data, ld_data;

    always #4 clk = ~clk;   // 125 MHz

    store_buffer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_writable(st_writable), .st_ready(st_ready),
        .bar_valid(bar_valid),
        .rdinv_valid(rdinv_valid), .rdinv_addr(rdinv_addr),
        .head_valid(head_valid), .head_addr(head_addr), .head_granted(head_granted),
        .cwr_valid(cwr_valid), .cwr_addr(cwr_addr), .cwr_data(cwr_data),
        .ld_addr(ld_addr), .cache_rd_data(cache_rd_data),
        .ld_hit(ld_hit), .ld_data(ld_data)
    );

    int n_run  = 0;
    int n_fail = 0;

    // Reference model state
    logic [7:0]  mq_a[$];
    logic [31:0] mq_d[$];
    bit          m_pend = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare, advance the model
    task automatic step(input bit sv, input logic [7:0] sa, input logic [31:0] sd,
                        input bit sw, input bit bv, input logic [7:0] la,
                        input logic [31:0] cd, input bit gr);
        bit e_ready, e_pop, e_acc, e_byp, e_push, e_hit, e_same;
        logic [31:0] e_fwd;
        st_valid = sv; st_addr = sa; st_data = sd; st_writable = sw;
        bar_valid = bv; ld_addr = la; cache_rd_data = cd; head_granted = gr;
        #1;
        e_ready = (mq_a.size() < DEPTH) && !m_pend;
        e_pop   = (mq_a.size() > 0) && gr;
        e_hit = 0; e_fwd = '0; e_same = 0;
        foreach (mq_a[i]) begin
            if (mq_a[i] == la) begin e_hit = 1; e_fwd = mq_d[i]; end
            if (mq_a[i] == sa) e_same = 1;
        end
        e_acc  = sv && e_ready;
        e_byp  = e_acc && sw && !e_pop && !e_same;
        e_push = e_acc && !e_byp;

        chk("R4/R7/R8/R9", "st_ready", st_ready, e_ready);
        chk("R1", "rdinv_valid", rdinv_valid, e_push);
        if (e_push) chk("R1", "rdinv_addr", rdinv_addr, sa);
        chk("R5", "head_valid", head_valid, mq_a.size() > 0);
        if (mq_a.size() > 0) chk("R5", "head_addr", head_addr, mq_a[0]);
        chk("R2/R6", "cwr_valid", cwr_valid, e_pop || e_byp);
        if (e_pop) begin
            chk("R2/R5", "cwr_addr", cwr_addr, mq_a[0]);
            chk("R2/R5", "cwr_data", cwr_data, mq_d[0]);
        end else if (e_byp) begin
            chk("R6", "cwr_addr", cwr_addr, sa);
            chk("R6", "cwr_data", cwr_data, sd);
        end
        chk("R3", "ld_hit", ld_hit, e_hit);
        chk("R3", "ld_data", ld_data, e_hit ? e_fwd : cd);

        if (e_pop)  begin void'(mq_a.pop_front()); void'(mq_d.pop_front()); end
        if (e_push) begin mq_a.push_back(sa); mq_d.push_back(sd); end
        m_pend = (m_pend || bv) && (mq_a.size() != 0);
        @(negedge clk);
    endtask

    task automatic idle(input bit gr);
        step(0, 8'h0, 32'h0, 0, 0, 8'h0, 32'hC0DE_0000, gr);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        st_valid = 0; st_addr = '0; st_data = '0; st_writable = 0;
        bar_valid = 0; ld_addr = '0; cache_rd_data = '0; head_granted = 0;
        repeat (3) @(negedge clk);
        // R9: reset state visible at the ports
        chk("R9", "st_ready in reset", st_ready, 1'b1);
        chk("R9", "head_valid in reset", head_valid, 1'b0);
        chk("R9", "cwr_valid in reset", cwr_valid, 1'b0);
        rst = 1'b0;
        idle(0);

        // R6: writable store into an empty queue bypasses
        step(1, 8'h10, 32'hAAAA_0001, 1, 0, 8'h10, 32'h1111, 0);
        // R1/R4: four parked stores, two to line 01
        step(1, 8'h01, 32'hD000_0001, 0, 0, 8'h01, 32'h2222, 0);
        step(1, 8'h02, 32'hD000_0002, 0, 0, 8'h01, 32'h2222, 0);
        step(1, 8'h01, 32'hD000_0003, 0, 0, 8'h01, 32'h2222, 0);
        step(1, 8'h03, 32'hD000_0004, 0, 0, 8'h02, 32'h2222, 0);
        // R4: full; offered store refused, R3 youngest match for line 01
        step(1, 8'h05, 32'hD000_0005, 1, 0, 8'h01, 32'h3333, 0);
        step(0, 8'h00, 32'h0, 0, 0, 8'h09, 32'h4444, 0);
        // R5: one grant commits the oldest
        step(0, 8'h00, 32'h0, 0, 0, 8'h01, 32'h5555, 1);
        // R6: writable store to an unrelated line bypasses
        step(1, 8'h07, 32'hB000_0007, 1, 0, 8'h07, 32'h6666, 0);
        // R6: writable store to a parked line must be queued
        step(1, 8'h02, 32'hB000_0002, 1, 0, 8'h02, 32'h6666, 0);
        step(0, 8'h00, 32'h0, 0, 0, 8'h02, 32'h6666, 1);
        // R7: barrier over a non-empty queue holds back writable stores
        step(0, 8'h00, 32'h0, 0, 1, 8'h00, 32'h0, 0);
        for (int k = 0; k < 4; k++)
            step(1, 8'h20, 32'hE000_0020, 1, 0, 8'h03, 32'h7777, 0);
        // R8: drain with grants while the store keeps knocking
        for (int k = 0; k < 6; k++)
            step(1, 8'h20, 32'hE000_0021, 1, 0, 8'h20, 32'h8888, 1);
        // R8: barrier over an empty queue has no effect
        step(0, 8'h00, 32'h0, 0, 1, 8'h00, 32'h0, 0);
        step(1, 8'h21, 32'hE000_0022, 1, 0, 8'h21, 32'h9999, 0);
        repeat (3) idle(1);

        // Mixed traffic over four line addresses
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], {6'h0, r[2:1]}, $urandom, r[3], (r[7:4] == 4'h0),
                 {6'h0, r[9:8]}, $urandom, (r[11:10] != 2'b00));
        end
        repeat (8) idle(1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule